// File: doc/BRIEF.md
# Monitor-Overlay Memory and Port Decoder

This block decodes the memory and I/O strobes of a small 8-bit system whose memory is a 256-byte RAM with a 32-byte monitor ROM over its lowest addresses. When the monitor is selected, reads from the bottom 32 locations come from the ROM. Writes to those locations always go to the RAM below it, so the ROM never drives the bus during a write. The block gates RAM writes with a protect flag and can turn the RAM off completely while power is unstable.

On the I/O side it produces two signals. The first is a latch enable for a two-digit output display; the block holds that display value in a register. The second is a strobe that places the hex keyboard word on the data bus. In single-step mode the display stops showing the latched value and follows the live data bus.

Top module: `mon_overlay_dec`

## Requirements
- R1: `romEn` is 1 exactly when `monSel`, `memRd` are 1 and address bits 7..5 of `addrLo` are all 0 (locations 0x00-0x1F).
- R2: `ramEn` is 1 exactly when `ramOff` is 0, `romEn` is 0 and at least one of `memRd`, `memWr` is 1.
- R3: A write (`memWr`=1, `memRd`=0) to any location 0x00-0x1F enables the RAM and keeps `romEn` at 0, whatever `monSel` is.
- R4: While `protect` is 1, `ramWe` stays 0. Otherwise `ramWe` equals `ramEn` AND `memWr`.
- R5: While `ramOff` is 1, both `ramEn` and `ramWe` stay 0.
- R6: `dispLe` is 1 exactly when `tpb` and `memRd` are 1 and at least one of `ioSel[2]` or `loadMode` is 1.
- R7: `dispLatch` resets to 0x00. It takes the value of `busData` on each rising clock edge where `dispLe` is 1, and otherwise holds its value.
- R8: `dispFromBus` equals `stepMode`. `dispOut` shows `busData` when `stepMode` is 1 and `dispLatch` when it is 0.
- R9: `kbdOe` is 1 exactly when `memRd` is 1 and at least one of `loadMode` or `ioSel[2]` is 1.
- R10: `romEn` and `ramEn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the display register |
| rstN | input | 1 | Asynchronous reset, active low |
| addrLo | input | 8 | Low address byte |
| memRd | input | 1 | Memory read strobe, active high |
| memWr | input | 1 | Memory write strobe, active high |
| tpb | input | 1 | Late timing pulse of the machine cycle |
| ioSel | input | 3 | I/O select lines; bit 2 picks the display/keyboard port |
| loadMode | input | 1 | Load mode flag |
| monSel | input | 1 | Monitor ROM selected |
| protect | input | 1 | Memory write protect |
| stepMode | input | 1 | Single-step mode flag |
| ramOff | input | 1 | Disables the RAM, active high |
| busData | input | 8 | Live data bus value |
| romEn | output | 1 | ROM enable |
| ramEn | output | 1 | RAM enable |
| ramWe | output | 1 | Gated RAM write |
| dispLe | output | 1 | Display latch enable |
| dispFromBus | output | 1 | Display source is the bus |
| kbdOe | output | 1 | Keyboard word onto bus |
| dispLatch | output | 8 | Latched display value |
| dispOut | output | 8 | Value shown on the display |

## Verification
All enables, the source select and `dispOut` are combinational. They are due in the same cycle as the input change, so the bench drives inputs on the falling edge and compares them with its reference model shortly before the next rising edge. `dispLatch` is the only result that lags: it changes on the first rising edge after `dispLe` is seen high. The model therefore records the bus value at that edge and compares `dispLatch` in the following cycle. Directed sequences cover the overlay boundary (0x1F/0x20), protected and disabled writes, and single-step switching. A long random run then exercises every combination of the flags.

// File: rtl/mon_overlay_pkg.sv
package mon_overlay_pkg;

  typedef struct packed {
    logic romEn;
    logic ramEn;
    logic ramWe;
    logic dispLe;
    logic dispFromBus;
    logic kbdOe;
  } strobe_t;

endpackage

// File: rtl/mon_overlay_ctrl.sv
module mon_overlay_ctrl
  import mon_overlay_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ROM_AW   = 5,
  parameter int IO_W     = 3,
  parameter int PORT_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic              memRd,
  input  logic              memWr,
  input  logic              tpb,
  input  logic [IO_W-1:0]   ioSel,
  input  logic              loadMode,
  input  logic              monSel,
  input  logic              protect,
  input  logic              stepMode,
  input  logic              ramOff,
  output strobe_t           strb
);

  localparam int HIGH_W = ADDR_W - ROM_AW;

  logic overlayHit;
  logic portSel;
  logic romSel;
  logic ramSel;

  // The ROM window is the part of the address space whose upper bits are all zero.
  assign overlayHit = (addrLo[ADDR_W-1:ROM_AW] == {HIGH_W{1'b0}});
  assign portSel    = ioSel[PORT_BIT] | loadMode;

  // The ROM is chosen only for reads, so writes in the window still reach the RAM.
  assign romSel = monSel & memRd & overlayHit;
  assign ramSel = ~ramOff & ~romSel & (memRd | memWr);

  always_comb begin
    strb.romEn       = romSel;
    strb.ramEn       = ramSel;
    strb.ramWe       = ramSel & memWr & ~protect;
    strb.dispLe      = tpb & memRd & portSel;
    strb.dispFromBus = stepMode;
    strb.kbdOe       = memRd & portSel;
  end

  p_rom_needs_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.romEn |-> (memRd && monSel));
  p_write_no_rom_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memRd) |-> !strb.romEn);
  p_protect_r4: assert property (@(posedge clk) disable iff (!rstN)
    protect |-> !strb.ramWe);
  p_ram_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramOff |-> (!strb.ramEn && !strb.ramWe));
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.romEn && strb.ramEn));
  p_le_implies_kbd_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispLe |-> strb.kbdOe);

endmodule

// File: rtl/mon_overlay_dp.sv
module mon_overlay_dp
  import mon_overlay_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] dispLatch,
  output logic [DATA_W-1:0] dispOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispLatch <= '0;
    end else if (strb.dispLe) begin
      dispLatch <= busData;
    end
  end

  assign dispOut = strb.dispFromBus ? busData : dispLatch;

  p_latch_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispLe |=> (dispLatch == $past(busData)));
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dispLe |=> $stable(dispLatch));
  p_step_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispFromBus |-> (dispOut == busData));

endmodule

// File: rtl/mon_overlay_dec.sv
module mon_overlay_dec
  import mon_overlay_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ROM_AW   = 5,
  parameter int DATA_W   = 8,
  parameter int IO_W     = 3,
  parameter int PORT_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic              memRd,
  input  logic              memWr,
  input  logic              tpb,
  input  logic [IO_W-1:0]   ioSel,
  input  logic              loadMode,
  input  logic              monSel,
  input  logic              protect,
  input  logic              stepMode,
  input  logic              ramOff,
  input  logic [DATA_W-1:0] busData,
  output logic              romEn,
  output logic              ramEn,
  output logic              ramWe,
  output logic              dispLe,
  output logic              dispFromBus,
  output logic              kbdOe,
  output logic [DATA_W-1:0] dispLatch,
  output logic [DATA_W-1:0] dispOut
);

  strobe_t strb;

  mon_overlay_ctrl #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .IO_W(IO_W), .PORT_BIT(PORT_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addrLo(addrLo), .memRd(memRd), .memWr(memWr),
    .tpb(tpb), .ioSel(ioSel), .loadMode(loadMode), .monSel(monSel),
    .protect(protect), .stepMode(stepMode), .ramOff(ramOff), .strb(strb)
  );

  mon_overlay_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busData(busData),
    .dispLatch(dispLatch), .dispOut(dispOut)
  );

  assign romEn       = strb.romEn;
  assign ramEn       = strb.ramEn;
  assign ramWe       = strb.ramWe;
  assign dispLe      = strb.dispLe;
  assign dispFromBus = strb.dispFromBus;
  assign kbdOe       = strb.kbdOe;

endmodule

// File: tb/mon_overlay_dec_tb.sv
module mon_overlay_dec_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addrLo = '0;
  logic       memRd = 0, memWr = 0, tpb = 0;
  logic [2:0] ioSel = '0;
  logic       loadMode = 0, monSel = 0, protect = 0, stepMode = 0, ramOff = 0;
  logic [7:0] busData = '0;
  logic       romEn, ramEn, ramWe, dispLe, dispFromBus, kbdOe;
  logic [7:0] dispLatch, dispOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] modelLatch = 8'h00;

  always #4 clk = ~clk;

  mon_overlay_dec u_dut (
    .clk(clk), .rstN(rstN), .addrLo(addrLo), .memRd(memRd), .memWr(memWr),
    .tpb(tpb), .ioSel(ioSel), .loadMode(loadMode), .monSel(monSel),
    .protect(protect), .stepMode(stepMode), .ramOff(ramOff), .busData(busData),
    .romEn(romEn), .ramEn(ramEn), .ramWe(ramWe), .dispLe(dispLe),
    .dispFromBus(dispFromBus), .kbdOe(kbdOe), .dispLatch(dispLatch), .dispOut(dispOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  task automatic compare();
    bit expRom, expRam, expWe, expLe, expKbd;
    int expOut;
    expRom = monSel && memRd && (addrLo < 8'h20);
    expRam = !ramOff && !expRom && (memRd || memWr);
    expWe  = expRam && memWr && !protect;
    expLe  = tpb && memRd && (ioSel[2] || loadMode);
    expKbd = memRd && (ioSel[2] || loadMode);
    expOut = stepMode ? int'(busData) : int'(modelLatch);
    chk("R1", "romEn", int'(romEn), int'(expRom));
    chk("R2", "ramEn", int'(ramEn), int'(expRam));
    chk("R4", "ramWe", int'(ramWe), int'(expWe));
    chk("R6", "dispLe", int'(dispLe), int'(expLe));
    chk("R9", "kbdOe", int'(kbdOe), int'(expKbd));
    chk("R8", "dispFromBus", int'(dispFromBus), int'(stepMode));
    chk("R8", "dispOut", int'(dispOut), expOut);
    chk("R7", "dispLatch", int'(dispLatch), int'(modelLatch));
    if (romEn && ramEn) chk("R10", "rom and ram both on", 1, 0);
    if (ramOff) chk("R5", "ram enables while off", int'(ramEn | ramWe), 0);
    if (protect) chk("R4", "write while protected", int'(ramWe), 0);
    if (memWr && !memRd && addrLo < 8'h20 && !ramOff)
      chk("R3", "overlay write to RAM", int'({romEn, ramEn}), 1);
  endtask

  // Inputs were driven on the falling edge; compare late in the low phase, then advance.
  task automatic cycle();
    bit le;
    #3;
    compare();
    le = tpb && memRd && (ioSel[2] || loadMode);
    @(posedge clk);
    if (le) modelLatch = busData;
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] a, input bit rd, input bit wr, input bit t,
                       input logic [2:0] io, input bit ld, input bit mon, input bit pr,
                       input bit st, input bit off, input logic [7:0] d);
    addrLo = a; memRd = rd; memWr = wr; tpb = t; ioSel = io; loadMode = ld;
    monSel = mon; protect = pr; stepMode = st; ramOff = off; busData = d;
    cycle();
  endtask

  initial begin
    @(negedge clk);
    #3;
    chk("R7", "reset dispLatch", int'(dispLatch), 0);
    chk("R2", "reset ramEn idle", int'(ramEn), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: overlay read boundary with monitor on and off
    drive(8'h00, 1, 0, 0, 3'b000, 0, 1, 0, 0, 0, 8'h11);
    drive(8'h1F, 1, 0, 0, 3'b000, 0, 1, 0, 0, 0, 8'h12);
    drive(8'h20, 1, 0, 0, 3'b000, 0, 1, 0, 0, 0, 8'h13);
    drive(8'h1F, 1, 0, 0, 3'b000, 0, 0, 0, 0, 0, 8'h14);
    // R3: writes in the overlay go to RAM with monitor selected
    drive(8'h05, 0, 1, 0, 3'b000, 0, 1, 0, 0, 0, 8'h15);
    drive(8'h1F, 0, 1, 0, 3'b000, 0, 1, 0, 0, 0, 8'h16);
    // R4: protected write
    drive(8'h40, 0, 1, 0, 3'b000, 0, 0, 1, 0, 0, 8'h17);
    // R5: RAM off during read and write
    drive(8'h80, 1, 0, 0, 3'b000, 0, 0, 0, 0, 1, 8'h18);
    drive(8'h80, 0, 1, 0, 3'b000, 0, 0, 0, 0, 1, 8'h19);
    // R6/R7: latch through port select, then through load mode, then no tpb
    drive(8'h00, 1, 0, 1, 3'b100, 0, 0, 0, 0, 0, 8'hA5);
    drive(8'h00, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 8'h00);
    chk("R7", "latched via port", int'(dispLatch), 8'hA5);
    drive(8'h00, 1, 0, 1, 3'b000, 1, 0, 0, 0, 0, 8'h3C);
    drive(8'h00, 1, 0, 0, 3'b100, 0, 0, 0, 0, 0, 8'hFF);
    chk("R7", "held without tpb", int'(dispLatch), 8'h3C);
    drive(8'h00, 1, 0, 1, 3'b011, 0, 0, 0, 0, 0, 8'h77);
    chk("R6", "low select bits ignored", int'(dispLatch), 8'h3C);
    // R8: single step shows the bus, then back to latch
    drive(8'h00, 0, 0, 0, 3'b000, 0, 0, 0, 1, 0, 8'h5A);
    drive(8'h00, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 8'h5A);
    chk("R8", "back to latch", int'(dispOut), 8'h3C);
    // R9: keyboard strobe
    drive(8'h00, 1, 0, 0, 3'b000, 1, 0, 0, 0, 0, 8'h00);
    drive(8'h00, 0, 0, 0, 3'b100, 1, 0, 0, 0, 0, 8'h00);
    // Random run covering all flag combinations
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] ? {3'b000, r[5:1]} : r[8:1], r[9], r[10], r[11], r[14:12], r[15],
            r[16], r[17], r[18], (r[21:19] == 3'b000), r[29:22]);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule